// File: doc/BRIEF.md
# Manchester Tag Frame Receiver

This block runs on the reader side of a low-frequency identification link. Its input is the tag's reply after demodulation and slicing: a Manchester-coded line sampled on the reader's carrier clock. One data bit lasts either 64 or 32 carrier clocks, and a static pin selects which. The receiver takes its bit timing from the transition that every Manchester bit carries at its centre. It hunts for a run of nine ones that marks the start of a frame, then gathers the 55 bits that follow.

Those 55 bits hold ten rows. Each row has four data bits and an even parity bit. After the rows come four even column parity bits and a stop bit of zero. The receiver checks every parity bit and the stop bit. A frame that fails any check raises a one-cycle error pulse.

Tags send their frame again and again. For that reason an identifier is released only when two good frames in a row carry the same value. The release is a one-cycle valid pulse, and the 40-bit value is held on the output until the next release. When the bit timing breaks, the frame in progress is dropped and the receiver waits for the next header.

Top module: `tagid_manchester_rx`

## Requirements
- R1: After reset, id_valid and frame_err are low and id_out is zero.
- R2: With long_bit high a bit lasts 64 clocks; with long_bit low it lasts 32. The line level just after a bit's centre transition is the bit's value: a rising centre edge gives 1 and a falling centre edge gives 0.
- R3: A frame starts after nine consecutive 1 bits. The next 55 bits are its body, sent in this order: for each of ten rows, four data bits and then a row parity bit; then four column parity bits; then the stop bit.
- R4: If any row's five bits (four data bits and the parity bit) have an odd number of ones, the frame is rejected with a frame_err pulse.
- R5: If a column parity bit together with the ten data bits in its column (the same position within each row) has an odd number of ones, the frame is rejected with a frame_err pulse.
- R6: If the stop bit is 1, the frame is rejected with a frame_err pulse.
- R7: id_valid pulses only for a good frame whose identifier equals that of the good frame just before it, with no rejected frame and no loss of lock between the two. The first good frame gives no pulse.
- R8: id_out changes only when id_valid pulses and is held at all other times. id_out[39] is the first data bit after the header, and within each row the first bit sent is the most significant.
- R9: id_valid and frame_err each last one clock and are never high together.
- R10: Loss of lock occurs on an edge less than a quarter period after the last centre edge, or when no centre edge arrives within 1.25 periods. Loss of lock discards the partial frame and clears the pairing of R7. An edge between a quarter and three quarters of a period is a bit-boundary edge and is ignored.
- R11: Two back-to-back good frames with different identifiers give no id_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| long_bit | input | 1 | Bit length select: 1 = 64 clocks, 0 = 32 clocks (static) |
| rx_line | input | 1 | Sliced Manchester line from the demodulator |
| id_out | output | 40 | Last released identifier |
| id_valid | output | 1 | One-cycle pulse when id_out is updated |
| frame_err | output | 1 | One-cycle pulse on a parity or stop-bit failure |

## Verification
The assertions assume that long_bit does not change while the receiver is locked, and that rx_line, apart from deliberate glitches, has clean edges at exact half-bit spacing. The bench drives every bit from the falling clock edge with exactly half a period in each half, and changes long_bit only while the line sits idle. The idle time between scenarios is longer than 1.25 periods, so lock and pairing are already cleared when each scenario starts. The one deliberate glitch is a two-clock pulse placed four clocks after a centre edge, which lands inside the early-edge window.

// File: rtl/tagid_manchester_rx.sv
module tagid_manchester_rx #(
  parameter int LONG_PERIOD  = 64,
  parameter int SHORT_PERIOD = 32,
  parameter int HDR_ONES     = 9,
  parameter int ROWS         = 10,
  parameter int NIB          = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 long_bit,
  input  logic                 rx_line,
  output logic [ROWS*NIB-1:0]  id_out,
  output logic                 id_valid,
  output logic                 frame_err
);
  localparam int BODY = ROWS*(NIB+1) + NIB + 1;
  localparam int IDW  = ROWS*NIB;
  localparam int CW   = $clog2(LONG_PERIOD*5/4 + 2);
  localparam int OW   = $clog2(HDR_ONES);
  localparam int NW   = $clog2(BODY);

  logic [1:0] sync;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], rx_line};

  wire tog   = sync[1] ^ sync[0];
  wire level = sync[0];

  wire [CW-1:0] w_q  = long_bit ? CW'(LONG_PERIOD/4)   : CW'(SHORT_PERIOD/4);
  wire [CW-1:0] w_lo = long_bit ? CW'(3*LONG_PERIOD/4) : CW'(3*SHORT_PERIOD/4);
  wire [CW-1:0] w_hi = long_bit ? CW'(5*LONG_PERIOD/4) : CW'(5*SHORT_PERIOD/4);

  logic [CW-1:0] cnt;
  logic          locked;
  wire  [CW-1:0] el = cnt + 1'b1;

  wire lose    = locked && ((tog && el < w_q) || (!tog && el > w_hi));
  wire mid_e   = tog && (!locked || (el >= w_lo && el <= w_hi));
  wire bit_stb = mid_e && !lose;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      if (lose)         locked <= 1'b0;
      else if (mid_e)   locked <= 1'b1;
      if (bit_stb)      cnt <= '0;
      else if (locked)  cnt <= cnt + 1'b1;
    end

  logic            hunting;
  logic [OW-1:0]   ones;
  logic [NW-1:0]   nbits;
  logic [BODY-2:0] sh;
  logic            have_prev;
  logic [IDW-1:0]  prev_id;

  wire [BODY-1:0] frame_now = {sh, level};
  logic [IDW-1:0] cand;
  logic           good;

  always_comb begin
    logic acc;
    good = ~frame_now[0];
    cand = '0;
    for (int r = 0; r < ROWS; r++) begin
      acc = 1'b0;
      for (int k = 0; k <= NIB; k++)
        acc = acc ^ frame_now[BODY-1 - r*(NIB+1) - k];
      good = good & ~acc;
      for (int k = 0; k < NIB; k++)
        cand[IDW-1 - r*NIB - k] = frame_now[BODY-1 - r*(NIB+1) - k];
    end
    for (int c = 0; c < NIB; c++) begin
      acc = frame_now[BODY-1 - ROWS*(NIB+1) - c];
      for (int r = 0; r < ROWS; r++)
        acc = acc ^ frame_now[BODY-1 - r*(NIB+1) - c];
      good = good & ~acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hunting   <= 1'b1;
      ones      <= '0;
      nbits     <= '0;
      sh        <= '0;
      have_prev <= 1'b0;
      prev_id   <= '0;
      id_out    <= '0;
      id_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      id_valid  <= 1'b0;
      frame_err <= 1'b0;
      if (lose) begin
        hunting   <= 1'b1;
        ones      <= '0;
        have_prev <= 1'b0;
      end else if (bit_stb) begin
        if (hunting) begin
          if (!level)
            ones <= '0;
          else if (ones == OW'(HDR_ONES-1)) begin
            hunting <= 1'b0;
            ones    <= '0;
            nbits   <= '0;
          end else
            ones <= ones + 1'b1;
        end else begin
          sh    <= frame_now[BODY-2:0];
          nbits <= nbits + 1'b1;
          if (nbits == NW'(BODY-1)) begin
            hunting <= 1'b1;
            if (good) begin
              prev_id   <= cand;
              have_prev <= 1'b1;
              if (have_prev && prev_id == cand) begin
                id_valid <= 1'b1;
                id_out   <= cand;
              end
            end else begin
              frame_err <= 1'b1;
              have_prev <= 1'b0;
            end
          end
        end
      end
    end
endmodule

// File: rtl/tagid_manchester_rx_chk.sv
module tagid_manchester_rx_chk #(
  parameter int IDW = 40,
  parameter int CW  = 7,
  parameter int LONG_PERIOD  = 64,
  parameter int SHORT_PERIOD = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           long_bit,
  input logic           id_valid,
  input logic           frame_err,
  input logic [IDW-1:0] id_out,
  input logic           locked,
  input logic [CW-1:0]  cnt
);
  a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && frame_err));

  a_r8_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> $stable(id_out));

  a_r10_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (int'(cnt) <= (long_bit ? 5*LONG_PERIOD/4 : 5*SHORT_PERIOD/4)));
endmodule

bind tagid_manchester_rx tagid_manchester_rx_chk #(
  .IDW(IDW), .CW(CW), .LONG_PERIOD(LONG_PERIOD), .SHORT_PERIOD(SHORT_PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .long_bit(long_bit), .id_valid(id_valid),
  .frame_err(frame_err), .id_out(id_out), .locked(locked), .cnt(cnt)
);

// File: tb/tagid_manchester_rx_test.sv
module tagid_manchester_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic long_bit = 1'b1;
  logic rx_line = 1'b0;
  logic [39:0] id_out;
  logic id_valid, frame_err;

  always #2.5 clk = ~clk;

  tagid_manchester_rx uut (
    .clk(clk), .rst_n(rst_n), .long_bit(long_bit), .rx_line(rx_line),
    .id_out(id_out), .id_valid(id_valid), .frame_err(frame_err)
  );

  int checks = 0, errors = 0;
  int vcnt = 0, ecnt = 0, wide = 0, both = 0;
  logic pv = 1'b0, pe = 1'b0;
  bit finished = 0;

  localparam logic [39:0] ID_A = 40'h12_3456_789A;
  localparam logic [39:0] ID_B = 40'hF0_0FA5_5A3C;
  localparam logic [39:0] ID_C = 40'h00_0000_0001;
  localparam logic [39:0] ID_D = 40'h00_0000_0002;

  always @(negedge clk) if (rst_n) begin
    if (id_valid) vcnt++;
    if (frame_err) ecnt++;
    if ((id_valid && pv) || (frame_err && pe)) wide++;
    if (id_valid && frame_err) both++;
    pv = id_valid;
    pe = frame_err;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [63:0] mk(input logic [39:0] id, input bit br,
                                     input bit bc, input bit bs);
    logic [63:0] f;
    logic [3:0] col, nib;
    int p;
    f = '0;
    col = '0;
    for (int i = 63; i >= 55; i--) f[i] = 1'b1;
    p = 54;
    for (int r = 0; r < 10; r++) begin
      nib = id[39-4*r -: 4];
      for (int k = 0; k < 4; k++) begin f[p] = nib[3-k]; p--; end
      f[p] = (^nib) ^ (br && r == 3); p--;
      col = col ^ nib;
    end
    for (int c = 0; c < 4; c++) begin f[p] = col[3-c] ^ (bc && c == 1); p--; end
    f[p] = bs;
    return f;
  endfunction

  task automatic send_bit(input logic v, input bit glitch);
    int h = long_bit ? 32 : 16;
    for (int i = 0; i < h; i++) begin @(negedge clk); rx_line = ~v; end
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      rx_line = (glitch && (i == 4 || i == 5)) ? ~v : v;
    end
  endtask

  task automatic send_frame(input logic [63:0] f, input int glitch_at);
    for (int i = 63; i >= 0; i--) send_bit(f[i], i == glitch_at);
  endtask

  task automatic idle(input bit lb);
    rx_line = 1'b0;
    repeat (200) @(negedge clk);
    long_bit = lb;
    repeat (20) @(negedge clk);
  endtask

  task automatic settle(); repeat (30) @(negedge clk); endtask

  task automatic t_reset();
    @(negedge clk);
    chk(id_valid === 1'b0, "R1", "id_valid in reset", {63'b0, id_valid}, 64'd0);
    chk(frame_err === 1'b0, "R1", "frame_err in reset", {63'b0, frame_err}, 64'd0);
    chk(id_out === 40'd0, "R1", "id_out in reset", {24'b0, id_out}, 64'd0);
  endtask

  task automatic t_long_repeat();
    int v0 = vcnt, e0 = ecnt;
    idle(1'b1);
    for (int n = 0; n < 3; n++) send_frame(mk(ID_A, 0, 0, 0), -1);
    settle();
    chk(vcnt - v0 == 2, "R7", "valid pulses for 3 equal frames (R2 R3)", vcnt - v0, 2);
    chk(ecnt == e0, "R4", "no error on good frames", ecnt - e0, 0);
    chk(id_out === ID_A, "R8", "id_out bit order", {24'b0, id_out}, {24'b0, ID_A});
  endtask

  task automatic t_short_rate();
    int v0 = vcnt;
    idle(1'b0);
    for (int n = 0; n < 2; n++) send_frame(mk(ID_B, 0, 0, 0), -1);
    settle();
    chk(vcnt - v0 == 1, "R2", "valid at 32-clock bits", vcnt - v0, 1);
    chk(id_out === ID_B, "R2", "id at 32-clock bits", {24'b0, id_out}, {24'b0, ID_B});
  endtask

  task automatic t_mismatch();
    int v0 = vcnt, e0 = ecnt;
    idle(1'b0);
    send_frame(mk(ID_C, 0, 0, 0), -1);
    send_frame(mk(ID_D, 0, 0, 0), -1);
    settle();
    chk(vcnt == v0, "R11", "no valid for differing ids", vcnt - v0, 0);
    chk(ecnt == e0, "R11", "no error for differing ids", ecnt - e0, 0);
    chk(id_out === ID_B, "R8", "id_out held", {24'b0, id_out}, {24'b0, ID_B});
  endtask

  task automatic t_row_err();
    int v0 = vcnt, e0 = ecnt;
    idle(1'b1);
    send_frame(mk(ID_A, 0, 0, 0), -1);
    send_frame(mk(ID_A, 1, 0, 0), -1);
    send_frame(mk(ID_A, 0, 0, 0), -1);
    send_frame(mk(ID_A, 0, 0, 0), -1);
    settle();
    chk(ecnt - e0 == 1, "R4", "row parity error pulse", ecnt - e0, 1);
    chk(vcnt - v0 == 1, "R7", "error breaks pairing", vcnt - v0, 1);
    chk(id_out === ID_A, "R8", "id after pairing", {24'b0, id_out}, {24'b0, ID_A});
  endtask

  task automatic t_col_err();
    int v0 = vcnt, e0 = ecnt;
    idle(1'b0);
    send_frame(mk(ID_B, 0, 1, 0), -1);
    settle();
    chk(ecnt - e0 == 1, "R5", "column parity error pulse", ecnt - e0, 1);
    chk(vcnt == v0, "R5", "no valid on column error", vcnt - v0, 0);
  endtask

  task automatic t_stop_err();
    int v0 = vcnt, e0 = ecnt;
    idle(1'b0);
    send_frame(mk(ID_B, 0, 0, 0), -1);
    send_frame(mk(ID_B, 0, 0, 1), -1);
    settle();
    chk(ecnt - e0 == 1, "R6", "stop bit error pulse", ecnt - e0, 1);
    chk(vcnt == v0, "R6", "no valid on stop error", vcnt - v0, 0);
    chk(id_out === ID_A, "R8", "id held over errors", {24'b0, id_out}, {24'b0, ID_A});
  endtask

  task automatic t_glitch();
    int v0 = vcnt, e0 = ecnt;
    idle(1'b1);
    send_frame(mk(ID_C, 0, 0, 0), -1);
    send_frame(mk(ID_C, 0, 0, 0), 40);
    send_frame(mk(ID_C, 0, 0, 0), -1);
    send_frame(mk(ID_C, 0, 0, 0), -1);
    settle();
    chk(vcnt - v0 == 1, "R10", "lock loss drops frame and pairing", vcnt - v0, 1);
    chk(ecnt == e0, "R10", "no error from dropped frame", ecnt - e0, 0);
    chk(id_out === ID_C, "R10", "id after relock", {24'b0, id_out}, {24'b0, ID_C});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_long_repeat();
    t_short_rate();
    t_mismatch();
    t_row_err();
    t_col_err();
    t_stop_err();
    t_glitch();
    chk(wide == 0, "R9", "pulses one cycle wide", wide, 0);
    chk(both == 0, "R9", "valid and error never together", both, 0);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual=running expected=done");
    summary();
  end
endmodule